// File: doc/BRIEF.md
# Last-In-First-Out Stack with Same-Cycle Forwarding

This block is a single-clock stack buffer. A push request stores the input word on top of the stack, a pop request moves the top word into a registered output, and a cycle that requests both forwards the input word to the output register without touching storage. One pointer is both the next write address and the count of held words. The stack reports when it holds nothing and when it can take no more. Parameters set the word width (default 8) and the number of storage slots (default 12, minimum 2).

Each cycle, a combinational classifier sorts the two request inputs and the two flags into one of six named operations. OP_IDLE means no request. OP_PUSH is an accepted push. OP_PUSH_REJECT is a push while full. OP_POP is an accepted pop. OP_POP_REJECT is a pop while empty. OP_BYPASS means both requests are high. The pointer, the storage array and the output register act on that classification at the next rising edge. The classification is redone every cycle from the current inputs and registered state. The transitions are as follows. OP_PUSH adds one to the pointer. OP_POP subtracts one. Every other operation leaves the pointer where it is. An active-high synchronous reset empties the stack.

Top module: `bypass_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer, every storage slot and `pop_data` are cleared. From the next cycle `stack_empty` is 1 and `stack_full` is 0.
- R2: A push alone (`push_req`=1, `pop_req`=0) while `stack_full` is 0 stores `push_data` on top. Words come back in reverse order of storage.
- R3: A pop alone (`pop_req`=1, `push_req`=0) while `stack_empty` is 0 removes the top word. That word appears on `pop_data` in the cycle after the request is sampled.
- R4: When both requests are 1, `pop_data` takes `push_data` in the following cycle. The held words, the pointer and both flags stay unchanged.
- R5: `stack_empty` is 1 exactly when no words are held. It is decoded combinationally from the registered pointer.
- R6: `stack_full` is a registered flag. It is 1 exactly when DEPTH-1 words are held. A push alone while it is 1 is ignored: no word is stored and the pointer holds.
- R7: A pop alone while `stack_empty` is 1 is ignored. `pop_data` keeps its previous value and the stack stays empty.
- R8: In any cycle without an accepted pop or a bypass, `pop_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Push request |
| push_data | input | DW | Word to push or forward |
| pop_req | input | 1 | Pop request |
| pop_data | output | DW | Registered popped or forwarded word |
| stack_full | output | 1 | Registered: DEPTH-1 words held |
| stack_empty | output | 1 | Combinational: no words held |

## Verification
All results of a request sampled at a rising edge are due one edge later. This covers the popped or forwarded word on `pop_data`, the registered full flag, and the empty flag, since the empty flag follows the pointer that the edge updates. The bench drives each request at a falling edge and lets exactly one rising edge pass. It then compares all three outputs at the next falling edge against a queue model that has applied the same request, so every comparison falls in the one cycle where the result must already be present. Ignored pushes are checked at the ports by later pops that return the earlier words, and ignored pops by `pop_data` and `stack_empty` holding their values.

// File: rtl/stack_pkg.sv
package stack_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_PUSH_REJECT,
        OP_POP,
        OP_POP_REJECT,
        OP_BYPASS
    } stack_op_t;

endpackage

// File: rtl/stack_op_decode.sv
module stack_op_decode
    import stack_pkg::*;
(
    input  logic      push_req,
    input  logic      pop_req,
    input  logic      full,
    input  logic      empty,
    output stack_op_t op
);

    always_comb begin
        unique case ({push_req, pop_req})
            2'b10:   op = full  ? OP_PUSH_REJECT : OP_PUSH;
            2'b01:   op = empty ? OP_POP_REJECT  : OP_POP;
            2'b11:   op = OP_BYPASS;
            default: op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
    import stack_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  stack_op_t     op,
    output logic [PW-1:0] ptr,
    output logic          full,
    output logic          empty
);

    localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_n;
    logic          full_q;

    always_comb begin
        unique case (op)
            OP_PUSH: ptr_n = ptr_q + PW'(1);
            OP_POP:  ptr_n = ptr_q - PW'(1);
            default: ptr_n = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
        end else begin
            ptr_q  <= ptr_n;
            full_q <= (ptr_n == TOP);
        end
    end

    assign ptr   = ptr_q;
    assign full  = full_q;
    assign empty = (ptr_q == '0);

endmodule

// File: rtl/stack_mem.sv
module stack_mem
    import stack_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 12,
    localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  stack_op_t     op,
    input  logic [PW-1:0] ptr,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] top_word
);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] rd_addr;

    assign rd_addr  = ptr - PW'(1);
    assign top_word = slots[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (op == OP_PUSH) begin
            slots[ptr] <= wr_word;
        end
    end

endmodule

// File: rtl/bypass_stack.sv
module bypass_stack
    import stack_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic          stack_full,
    output logic          stack_empty
);

    localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    stack_op_t     op;
    logic [PW-1:0] ptr;
    logic [DW-1:0] top_word;
    logic [DW-1:0] out_q;

    stack_op_decode u_decode (
        .push_req (push_req),
        .pop_req  (pop_req),
        .full     (stack_full),
        .empty    (stack_empty),
        .op       (op)
    );

    stack_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .ptr   (ptr),
        .full  (stack_full),
        .empty (stack_empty)
    );

    stack_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ptr      (ptr),
        .wr_word  (push_data),
        .top_word (top_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            unique case (op)
                OP_POP:    out_q <= top_word;
                OP_BYPASS: out_q <= push_data;
                default:   out_q <= out_q;
            endcase
        end
    end

    assign pop_data = out_q;

endmodule

// File: rtl/bypass_stack_chk.sv
module bypass_stack_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 12,
    parameter int PW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          push_req,
    input logic [DW-1:0] push_data,
    input logic          pop_req,
    input logic [DW-1:0] pop_data,
    input logic          stack_full,
    input logic          stack_empty,
    input logic [PW-1:0] ptr
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stack_empty && !stack_full && pop_data == '0));

    // R2
    push_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !stack_full) |=> !stack_empty);

    // R3
    pop_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !stack_empty) |=> (ptr == $past(ptr) - PW'(1)));

    // R4
    bypass_data_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> (pop_data == $past(push_data)));

    // R4
    bypass_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> ($stable(ptr) && $stable(stack_full)));

    // R6
    full_level_chk: assert property (@(posedge clk) disable iff (rst)
        stack_full == (ptr == PW'(DEPTH - 1)));

    // R6
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (stack_full && push_req && !pop_req) |=> (stack_full && $stable(ptr)));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (stack_empty && pop_req && !push_req) |=> (stack_empty && $stable(pop_data)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pop_req |=> $stable(pop_data));

endmodule

bind bypass_stack bypass_stack_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_req    (push_req),
    .push_data   (push_data),
    .pop_req     (pop_req),
    .pop_data    (pop_data),
    .stack_full  (stack_full),
    .stack_empty (stack_empty),
    .ptr         (ptr)
);

// File: tb/bypass_stack_test.sv
module bypass_stack_test;

    localparam int DW    = 8;
    localparam int DEPTH = 12;
    localparam int CAP   = DEPTH - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] pop_data;
    logic          stack_full;
    logic          stack_empty;

    int            n_cmp  = 0;
    int            n_bad  = 0;
    bit            done   = 1'b0;
    int            model [$];
    logic [DW-1:0] exp_data = '0;

    always #4 clk = ~clk;

    bypass_stack #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk         (clk),
        .rst         (rst),
        .push_req    (push_req),
        .push_data   (push_data),
        .pop_req     (pop_req),
        .pop_data    (pop_data),
        .stack_full  (stack_full),
        .stack_empty (stack_empty)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, pop_data, exp_data);
        check("R5 empty", DW'(stack_empty), DW'(model.size() == 0));
        check("R6 full", DW'(stack_full), DW'(model.size() == CAP));
    endtask

    task automatic step(bit p, bit r, logic [DW-1:0] d);
        string tag;
        push_req  = p;
        pop_req   = r;
        push_data = d;
        if (p && r) begin
            exp_data = d;
            tag = "R4 bypass";
        end else if (p) begin
            if (model.size() < CAP) begin
                model.push_back(int'(d));
                tag = "R2 push";
            end else begin
                tag = "R6 push when full";
            end
        end else if (r) begin
            if (model.size() > 0) begin
                exp_data = DW'(model.pop_back());
                tag = "R3 pop";
            end else begin
                tag = "R7 pop when empty";
            end
        end else begin
            tag = "R8 idle hold";
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        push_req = 1'b0;
        pop_req  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model.delete();
        exp_data = '0;
        check("R1 data", pop_data, '0);
        check("R1 empty", DW'(stack_empty), DW'(1));
        check("R1 full", DW'(stack_full), DW'(0));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R7: pops on an empty stack
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        // R2: fill to capacity
        for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, DW'(8'h10 + i));
        // R6: pushes while full are ignored
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b0, 8'hEF);
        // R4: forwarding while full
        step(1'b1, 1'b1, 8'hA5);
        step(1'b0, 1'b0, 8'h00);
        // R3: drain, words come back reversed
        for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, 8'h00);
        // R7 after drain, then R4 while empty
        step(1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b1, 8'h5A);
        step(1'b0, 1'b1, 8'h00);
        // R1: reset with content held
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(8'h30 + i));
        step(1'b0, 1'b1, 8'h00);
        do_reset();
        step(1'b0, 1'b1, 8'h00);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom_range(0, 9));
            step(sel < 5 || sel == 9, sel >= 5, DW'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule